// File: doc/BRIEF.md
# Reference Block Line Streamer

This block feeds a sub-pixel motion-compensation interpolator with reference pixels. A command names a block size and the block's top-left position in the picture. The block then walks a padded window around that block one line at a time. For each line it first fixes the row address, then reads that row's pixels from a synchronous frame memory and passes each one straight to a valid/ready output stream. No block-sized buffer sits between memory and output, so each pixel costs one memory read and no store or reload.

The window covers two pixels before the block and three after it in both directions, so it is (W+5)×(H+5) pixels. Window coordinates that fall outside the picture are clamped to the nearest edge pixel. A single-cycle done pulse marks the end of a window. A new command is taken only while the block is idle.

Top module: `refLineStreamer`

## Requirements
- R1: After reset, cmdReady is 1 and pixValid, done and memRdEn are 0.
- R2: The size codes cmdWCode and cmdHCode each select 0 → 4, 1 → 8, 2 or 3 → 16 pixels, which covers the seven supported block sizes 4×4, 4×8, 8×4, 8×8, 8×16, 16×8 and 16×16. A command streams exactly (W+5)×(H+5) pixels, and pixEol is 1 on the last pixel of each of the H+5 lines and 0 elsewhere.
- R3: Pixels leave in row-major order starting at window origin (cmdX−2, cmdY−2). Window pixel (i, j) carries memory word (cmdY−2+j)·FRAME_W + (cmdX−2+i).
- R4: A window x coordinate below 0 or above FRAME_W−1 is replaced by 0 or FRAME_W−1, and y is clamped the same way against FRAME_H.
- R5: memAddr is within the frame whenever memRdEn is 1. The read data arrives one cycle after the read. The memory keeps its output word while no read is issued. pixData is that read word.
- R6: While pixValid is 1 and pixReady is 0, no read is issued, and pixValid, pixData and pixEol stay unchanged.
- R7: done is high for exactly one cycle, starting in the cycle after the last window pixel is accepted, and cmdReady returns to 1 in that same cycle. cmdValid has no effect while a window is being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command taken when cmdValid is high |
| cmdWCode | input | 2 | Block width code |
| cmdHCode | input | 2 | Block height code |
| cmdX | input | X_W | Block left column in the picture |
| cmdY | input | Y_W | Block top row in the picture |
| memRdEn | output | 1 | Frame memory read strobe |
| memAddr | output | ADDR_W | Frame memory word address |
| memRdData | input | 8 | Frame memory read data, one cycle after the read |
| pixValid | output | 1 | Output pixel valid |
| pixReady | input | 1 | Interpolator accepts a pixel |
| pixData | output | 8 | Output pixel |
| pixEol | output | 1 | Last pixel of a window line |
| done | output | 1 | Window finished pulse |

## Verification
A wrong row base or column offset shows at the ports on the very first pixel of the affected line as a value from the wrong memory word. Clamping errors appear only on windows touching a picture edge, which is why commands are aimed at all four borders and corners. A miscounted window length shows as pixEol on the wrong pixel, or as done arriving early or late against the (W+5)×(H+5) count. A stall-handling fault shows within one cycle as a changed pixel or a dropped valid while ready is low.

// File: rtl/refls_pkg.sv
package refls_pkg;
  localparam int WIN_CNT_W = 5;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ROW,
    S_PIX,
    S_DRAIN
  } lsState_e;

  typedef struct packed {
    logic load;
    logic setRow;
    logic rd;
  } lsStrobe_t;
endpackage

// File: rtl/refls_ctrl.sv
module refls_ctrl
  import refls_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdWCode,
  input  logic [1:0]           cmdHCode,
  output logic                 cmdReady,
  input  logic                 pixReady,
  output logic                 pixValid,
  output logic                 pixEol,
  output logic                 done,
  output lsStrobe_t            strobe,
  output logic [WIN_CNT_W-1:0] rowIdx,
  output logic [WIN_CNT_W-1:0] colIdx
);
  lsState_e state, nxtState;
  logic [WIN_CNT_W-1:0] winW, winH;
  logic canRd, lastCol, lastRow;

  function automatic logic [WIN_CNT_W-1:0] winOf(input logic [1:0] code);
    case (code)
      2'd0:    winOf = WIN_CNT_W'(9);
      2'd1:    winOf = WIN_CNT_W'(13);
      default: winOf = WIN_CNT_W'(21);
    endcase
  endfunction

  assign canRd    = !pixValid || pixReady;
  assign lastCol  = (colIdx == winW - 1'b1);
  assign lastRow  = (rowIdx == winH - 1'b1);
  assign cmdReady = (state == S_IDLE);

  always_comb begin
    strobe   = '0;
    nxtState = state;
    case (state)
      S_IDLE: if (cmdValid) begin
        strobe.load = 1'b1;
        nxtState    = S_ROW;
      end
      S_ROW: begin
        strobe.setRow = 1'b1;
        nxtState      = S_PIX;
      end
      S_PIX: if (canRd) begin
        strobe.rd = 1'b1;
        if (lastCol) nxtState = lastRow ? S_DRAIN : S_ROW;
      end
      default: if (pixValid && pixReady) nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      winW     <= '0;
      winH     <= '0;
      rowIdx   <= '0;
      colIdx   <= '0;
      pixValid <= 1'b0;
      pixEol   <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nxtState;
      if (strobe.load) begin
        winW   <= winOf(cmdWCode);
        winH   <= winOf(cmdHCode);
        rowIdx <= '0;
        colIdx <= '0;
      end
      if (strobe.rd) begin
        pixEol <= lastCol;
        if (lastCol) begin
          colIdx <= '0;
          rowIdx <= rowIdx + 1'b1;
        end else begin
          colIdx <= colIdx + 1'b1;
        end
      end
      if (strobe.rd)     pixValid <= 1'b1;
      else if (pixReady) pixValid <= 1'b0;
      done <= (state == S_DRAIN) && pixValid && pixReady;
    end
  end
endmodule

// File: rtl/refls_dp.sv
module refls_dp
  import refls_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int X_W     = $clog2(FRAME_W),
  parameter int Y_W     = $clog2(FRAME_H),
  parameter int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lsStrobe_t            strobe,
  input  logic [X_W-1:0]       cmdX,
  input  logic [Y_W-1:0]       cmdY,
  input  logic [WIN_CNT_W-1:0] rowIdx,
  input  logic [WIN_CNT_W-1:0] colIdx,
  output logic                 memRdEn,
  output logic [ADDR_W-1:0]    memAddr
);
  localparam int XY_W = (X_W > Y_W) ? X_W : Y_W;
  localparam int MX_W = (XY_W > WIN_CNT_W) ? XY_W : WIN_CNT_W;
  localparam int SW   = MX_W + 2;
  localparam logic signed [SW-1:0] MAX_X = SW'(FRAME_W - 1);
  localparam logic signed [SW-1:0] MAX_Y = SW'(FRAME_H - 1);
  localparam logic signed [SW-1:0] PAD   = SW'(2);

  logic [X_W-1:0]    baseX, clampX;
  logic [Y_W-1:0]    baseY, clampY;
  logic [ADDR_W-1:0] rowBase;
  logic signed [SW-1:0] rawX, rawY;

  always_comb begin
    rawX = $signed(SW'(baseX)) + $signed(SW'(colIdx)) - PAD;
    rawY = $signed(SW'(baseY)) + $signed(SW'(rowIdx)) - PAD;
    if (rawX < 0)          clampX = '0;
    else if (rawX > MAX_X) clampX = X_W'(FRAME_W - 1);
    else                   clampX = rawX[X_W-1:0];
    if (rawY < 0)          clampY = '0;
    else if (rawY > MAX_Y) clampY = Y_W'(FRAME_H - 1);
    else                   clampY = rawY[Y_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseX   <= '0;
      baseY   <= '0;
      rowBase <= '0;
    end else begin
      if (strobe.load) begin
        baseX <= cmdX;
        baseY <= cmdY;
      end
      if (strobe.setRow) rowBase <= ADDR_W'(clampY) * ADDR_W'(FRAME_W);
    end
  end

  assign memRdEn = strobe.rd;
  assign memAddr = rowBase + ADDR_W'(clampX);
endmodule

// File: rtl/refLineStreamer.sv
module refLineStreamer
  import refls_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int X_W     = $clog2(FRAME_W),
  parameter int Y_W     = $clog2(FRAME_H),
  parameter int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdWCode,
  input  logic [1:0]        cmdHCode,
  input  logic [X_W-1:0]    cmdX,
  input  logic [Y_W-1:0]    cmdY,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              pixValid,
  input  logic              pixReady,
  output logic [7:0]        pixData,
  output logic              pixEol,
  output logic              done
);
  lsStrobe_t            strobe;
  logic [WIN_CNT_W-1:0] rowIdx, colIdx;

  refls_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWCode(cmdWCode),
    .cmdHCode(cmdHCode), .cmdReady(cmdReady), .pixReady(pixReady),
    .pixValid(pixValid), .pixEol(pixEol), .done(done), .strobe(strobe),
    .rowIdx(rowIdx), .colIdx(colIdx)
  );

  refls_dp #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdX(cmdX), .cmdY(cmdY),
    .rowIdx(rowIdx), .colIdx(colIdx), .memRdEn(memRdEn), .memAddr(memAddr)
  );

  assign pixData = memRdData;
endmodule

// File: rtl/refLineStreamer_chk.sv
module refLineStreamer_chk #(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int ADDR_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pixValid,
  input logic              pixReady,
  input logic              pixEol,
  input logic              done
);
  localparam int LAST_ADDR = FRAME_W * FRAME_H - 1;

  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |-> !memRdEn); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> pixValid && $stable(pixEol)); // R6
  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> int'(memAddr) <= LAST_ADDR); // R5
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(pixValid && pixReady)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !pixValid && !memRdEn); // R7
endmodule

bind refLineStreamer refLineStreamer_chk #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .memRdEn(memRdEn),
  .memAddr(memAddr), .pixValid(pixValid), .pixReady(pixReady),
  .pixEol(pixEol), .done(done)
);

// File: tb/refLineStreamer_bench.sv
module refLineStreamer_bench;
  localparam int FW = 64;
  localparam int FH = 48;
  localparam int XW = $clog2(FW);
  localparam int YW = $clog2(FH);
  localparam int AW = $clog2(FW * FH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [1:0] cmdWCode = '0, cmdHCode = '0;
  logic [XW-1:0] cmdX = '0;
  logic [YW-1:0] cmdY = '0;
  logic memRdEn;
  logic [AW-1:0] memAddr;
  logic [7:0] memQ = '0;
  logic pixValid, pixReady = 1'b0, pixEol, done;
  logic [7:0] pixData;
  logic [7:0] mem [FW*FH];

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  refLineStreamer #(.FRAME_W(FW), .FRAME_H(FH)) u_refLineStreamer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWCode(cmdWCode), .cmdHCode(cmdHCode), .cmdX(cmdX), .cmdY(cmdY),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memQ),
    .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
    .pixEol(pixEol), .done(done)
  );

  always @(posedge clk) if (memRdEn) memQ <= mem[memAddr];

  function automatic int memVal(int a);
    return (a * 37 + (a >> 5) * 11 + 5) & 255;
  endfunction

  function automatic int winOf(int code);
    return (code == 0) ? 9 : (code == 1) ? 13 : 21;
  endfunction

  function automatic int clampTo(int v, int lim);
    return (v < 0) ? 0 : (v > lim - 1) ? lim - 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input int wc, input int hc, input int x, input int y,
                        input int readyPct, input bit busyCmd);
    int w5, total, k;
    bit stalled;
    int prevData, prevEol;
    w5 = winOf(wc);
    total = w5 * winOf(hc);
    @(negedge clk);
    cmdValid = 1'b1; cmdWCode = 2'(wc); cmdHCode = 2'(hc);
    cmdX = XW'(x); cmdY = YW'(y);
    @(negedge clk);
    if (busyCmd) begin
      cmdWCode = 2'(3 - wc); cmdHCode = 2'(hc ^ 1);
      cmdX = XW'(x + 17); cmdY = YW'((y + 9) % FH);
    end else cmdValid = 1'b0;
    k = 0; stalled = 0; prevData = 0; prevEol = 0;
    while (k < total) begin
      pixReady = (($urandom % 100) < readyPct);
      if (stalled) begin
        chk(pixValid === 1'b1, "R6", "valid held in stall", int'(pixValid), 1);
        chk(int'(pixData) == prevData && int'(pixEol) == prevEol, "R6",
            "data held in stall", int'(pixData), prevData);
      end
      if (pixValid && pixReady) begin
        int i, j, cx, cy, ex;
        bit clip;
        i = k % w5; j = k / w5;
        cx = clampTo(x - 2 + i, FW); cy = clampTo(y - 2 + j, FH);
        clip = (cx != x - 2 + i) || (cy != y - 2 + j);
        ex = memVal(cy * FW + cx);
        if (clip) chk(int'(pixData) == ex, "R4", "clamped pixel", int'(pixData), ex);
        else      chk(int'(pixData) == ex, "R3", "window pixel", int'(pixData), ex);
        chk(int'(pixEol) == int'(i == w5 - 1), "R2", "line end flag",
            int'(pixEol), int'(i == w5 - 1));
        k++;
        if (k == total && busyCmd) cmdValid = 1'b0;
        stalled = 0;
      end else if (pixValid) begin
        stalled = 1; prevData = int'(pixData); prevEol = int'(pixEol);
      end else stalled = 0;
      @(negedge clk);
    end
    pixReady = 1'b0;
    chk(done === 1'b1, "R7", "done after last pixel", int'(done), 1);
    chk(cmdReady === 1'b1, "R7", "idle with done", int'(cmdReady), 1);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done single cycle", int'(done), 0);
    chk(pixValid === 1'b0, "R2", "no extra pixel", int'(pixValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int sizes [7][2];
    sizes = '{'{0,0}, '{0,1}, '{1,0}, '{1,1}, '{2,1}, '{1,2}, '{2,2}};
    process::self().srandom(32'd1234);
    for (int a = 0; a < FW * FH; a++) mem[a] = 8'(memVal(a));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady === 1'b1, "R1", "reset cmdReady", int'(cmdReady), 1);
    chk(pixValid === 1'b0, "R1", "reset pixValid", int'(pixValid), 0);
    chk(done === 1'b0, "R1", "reset done", int'(done), 0);
    chk(memRdEn === 1'b0, "R1", "reset memRdEn", int'(memRdEn), 0);

    // R2 R3: every supported size in the middle of the picture
    for (int s = 0; s < 7; s++) runCmd(sizes[s][0], sizes[s][1], 20, 18, 100, 0);
    // R2: code 3 behaves as 16
    runCmd(3, 3, 24, 20, 100, 0);
    // R4: corners and edges
    runCmd(2, 2, 0, 0, 100, 0);
    runCmd(2, 2, FW - 1, FH - 1, 80, 0);
    runCmd(0, 0, 1, FH - 2, 60, 0);
    runCmd(1, 2, FW - 3, 0, 70, 0);
    // R6: heavy back-pressure
    runCmd(1, 1, 30, 30, 25, 0);
    // R7: cmdValid held with other fields during a window
    runCmd(2, 1, 10, 12, 70, 1);
    // random mix
    for (int r = 0; r < 20; r++) begin
      int s;
      s = int'($urandom % 7);
      runCmd(sizes[s][0], sizes[s][1], int'($urandom % FW), int'($urandom % FH),
             40 + int'($urandom % 61), 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule